// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler

This block collects sector-erase requests for a small flash-style controller and then carries out the erase one sector at a time. The first valid request opens an acceptance window. Each further request that arrives while the window is open adds its sector to a pending mask and starts the window again at its full length. When the window runs out, the pending sectors are erased in ascending index order. Each sector costs a fixed number of clock cycles.

While the window is open, a suspend request ends the window at once and parks the block. An abort request drops the whole job. Once erasing has begun, the only requests that act are suspend and termination:
- A suspend takes effect after a fixed latency, and the interrupted sector keeps its progress.
- After a resume, a fresh suspend is refused until a guard interval has elapsed.
- A termination request ends any job after a short fixed latency.

The window length, the per-sector cost and the three latencies are parameters given in clock cycles, and each must be at least 1.

Top module: `multi_erase_sched`

## Requirements
- R1: After reset, busy, window_open, suspended and done are 0 and cur_sector is 0.
- R2: In idle, an erase_req whose erase_sector is below NUM_SECTORS opens the window. window_open and busy are then 1 for exactly WINDOW_CYC cycles. An index of NUM_SECTORS or more is ignored.
- R3: A valid erase_req during the window adds that sector to the pending set and restarts the window at WINDOW_CYC cycles.
- R4: When the window expires, the pending sectors are erased from the lowest index upward. Each takes exactly SECTOR_CYC cycles of erasing, and cur_sector shows the sector being worked on.
- R5: done is a one-cycle pulse in the cycle after the last pending sector completes, and busy is 0 in that same cycle.
- R6: abort_req during the window returns the block to idle in the next cycle with no sector erased and no done pulse.
- R7: Once erasing has begun, erase_req, abort_req and resume_req have no effect on the outputs or on the remaining duration.
- R8: suspend_req during the window moves the block to the suspended state in the next cycle: suspended is 1, busy is 0 and window_open is 0.
- R9: suspend_req during erasing keeps busy at 1 and suspended at 0 for exactly SUSP_LAT cycles, then sets suspended to 1 and busy to 0.
- R10: resume_req in the suspended state restarts erasing. The interrupted sector runs only its remaining cycles, and the other pending sectors follow.
- R11: During erasing, suspend_req is ignored until RESUME_GUARD cycles have passed since the last accepted resume.
- R12: term_req in any non-idle state keeps busy at 1 for exactly TERM_LAT cycles, then returns to idle with the pending set cleared and no done pulse. In idle, term_req has no effect.
- R13: Requests arriving in the same cycle are ranked term_req, then abort_req, then suspend_req, then erase_req. A valid erase_req is accepted in every cycle in which window_open is 1, including the last cycle of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_req | input | 1 | Sector-erase request pulse |
| erase_sector | input | IDX_W | Sector index carried with erase_req |
| suspend_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| abort_req | input | 1 | Any other command; aborts during the window |
| term_req | input | 1 | Hardware termination pulse |
| busy | output | 1 | Window open, erasing, suspend pending or terminating |
| window_open | output | 1 | Acceptance window is running |
| suspended | output | 1 | Parked in the suspended state |
| cur_sector | output | IDX_W | Lowest pending sector while erasing or suspended, else 0 |
| done | output | 1 | One-cycle pulse when the pending set empties |

## Verification
The case that needs care is a new sector request landing in the same cycle as the window's expiry. In that cycle the request must win: the sector joins the pending set and the window runs another full WINDOW_CYC cycles instead of erasing starting. The bench reads its own model's window count to place a request on exactly that final cycle. It then compares window_open, busy and cur_sector every cycle until the resulting erase completes. Requests that arrive together (term with abort, abort with suspend, suspend with erase) are driven in the same cycle and judged against the ranking in R13.

// File: rtl/esch_pkg.sv
package esch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WINDOW = 3'd1,
        ST_ERASE  = 3'd2,
        ST_SWAIT  = 3'd3,
        ST_SUSP   = 3'd4,
        ST_TERM   = 3'd5
    } esch_state_e;

endpackage

// File: rtl/esch_low_pick.sv
module esch_low_pick #(
    parameter int N     = 7,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);

    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // R4: at most one sector is selected at a time
    always_comb begin
        assert_grant_onehot_R4: assert ($onehot0(grant));
    end

endmodule

// File: rtl/esch_guard_timer.sv
module esch_guard_timer #(
    parameter int CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);

    // R11: a resume always opens a guard interval
    assert_guard_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !idle);

    // R11: once expired, the guard stays expired until the next resume
    assert_guard_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !load) |=> idle);

endmodule

// File: rtl/multi_erase_sched.sv
module multi_erase_sched
    import esch_pkg::*;
#(
    parameter int NUM_SECTORS  = 7,
    parameter int IDX_W        = $clog2(NUM_SECTORS),
    parameter int WINDOW_CYC   = 50,
    parameter int SECTOR_CYC   = 60,
    parameter int SUSP_LAT     = 20,
    parameter int RESUME_GUARD = 40,
    parameter int TERM_LAT     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase_req,
    input  logic [IDX_W-1:0] erase_sector,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             abort_req,
    input  logic             term_req,
    output logic             busy,
    output logic             window_open,
    output logic             suspended,
    output logic [IDX_W-1:0] cur_sector,
    output logic             done
);

    localparam int TMR_MAX = (WINDOW_CYC > SUSP_LAT)
                           ? ((WINDOW_CYC > TERM_LAT) ? WINDOW_CYC : TERM_LAT)
                           : ((SUSP_LAT > TERM_LAT) ? SUSP_LAT : TERM_LAT);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int PROG_W  = $clog2(SECTOR_CYC + 1);

    typedef struct packed {
        esch_state_e            state;
        logic [NUM_SECTORS-1:0] mask;
        logic [TMR_W-1:0]       tmr;
        logic [PROG_W-1:0]      prog;
        logic                   done;
    } esch_regs_t;

    localparam esch_regs_t RESET_VAL = '{
        state: ST_IDLE, mask: '0, tmr: '0, prog: '0, done: 1'b0
    };

    esch_regs_t r_d, r_q;

    logic [NUM_SECTORS-1:0] req_bit;
    logic                   req_valid;
    logic [NUM_SECTORS-1:0] grant_oh;
    logic [IDX_W-1:0]       pick_idx;
    logic                   guard_idle;
    logic                   resume_take;
    logic [NUM_SECTORS-1:0] mask_left;

    // decode the request index into a one-hot sector bit
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_req
        assign req_bit[i] = erase_req && (erase_sector == IDX_W'(i));
    end
    assign req_valid = |req_bit;

    esch_low_pick #(
        .N     (NUM_SECTORS),
        .IDX_W (IDX_W)
    ) u_pick (
        .req   (r_q.mask),
        .grant (grant_oh),
        .idx   (pick_idx)
    );

    assign resume_take = (r_q.state == ST_SUSP) && resume_req && !term_req;

    esch_guard_timer #(
        .CYC (RESUME_GUARD)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (resume_take),
        .idle  (guard_idle)
    );

    assign mask_left = r_q.mask & ~grant_oh;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_WINDOW;
                    r_d.mask  = req_bit;
                    r_d.tmr   = TMR_W'(WINDOW_CYC);
                end
            end
            ST_WINDOW: begin
                if (term_req) begin
                    r_d.state = ST_TERM;
                    r_d.tmr   = TMR_W'(TERM_LAT);
                end else if (abort_req) begin
                    r_d.state = ST_IDLE;
                    r_d.mask  = '0;
                    r_d.tmr   = '0;
                end else if (suspend_req) begin
                    r_d.state = ST_SUSP;
                    r_d.tmr   = '0;
                    r_d.prog  = '0;
                end else if (req_valid) begin
                    r_d.mask = r_q.mask | req_bit;
                    r_d.tmr  = TMR_W'(WINDOW_CYC);
                end else if (r_q.tmr == TMR_W'(1)) begin
                    r_d.state = ST_ERASE;
                    r_d.tmr   = '0;
                    r_d.prog  = '0;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_ERASE: begin
                if (term_req) begin
                    r_d.state = ST_TERM;
                    r_d.tmr   = TMR_W'(TERM_LAT);
                end else if (suspend_req && guard_idle) begin
                    r_d.state = ST_SWAIT;
                    r_d.tmr   = TMR_W'(SUSP_LAT);
                end else if (r_q.prog == PROG_W'(SECTOR_CYC - 1)) begin
                    r_d.mask = mask_left;
                    r_d.prog = '0;
                    if (mask_left == '0) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end else begin
                    r_d.prog = r_q.prog + PROG_W'(1);
                end
            end
            ST_SWAIT: begin
                if (term_req) begin
                    r_d.state = ST_TERM;
                    r_d.tmr   = TMR_W'(TERM_LAT);
                end else if (r_q.tmr == TMR_W'(1)) begin
                    r_d.state = ST_SUSP;
                    r_d.tmr   = '0;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_SUSP: begin
                if (term_req) begin
                    r_d.state = ST_TERM;
                    r_d.tmr   = TMR_W'(TERM_LAT);
                end else if (resume_req) begin
                    r_d.state = ST_ERASE;
                end
            end
            ST_TERM: begin
                if (r_q.tmr == TMR_W'(1)) begin
                    r_d = RESET_VAL;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.state == ST_WINDOW) || (r_q.state == ST_ERASE) ||
                         (r_q.state == ST_SWAIT)  || (r_q.state == ST_TERM);
    assign window_open = (r_q.state == ST_WINDOW);
    assign suspended   = (r_q.state == ST_SUSP);
    assign cur_sector  = ((r_q.state == ST_ERASE) || (r_q.state == ST_SWAIT) ||
                          (r_q.state == ST_SUSP)) ? pick_idx : '0;
    assign done        = r_q.done;

    // R2: the window is always counted as busy time
    assert_window_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> busy);

    // R5: done follows a busy cycle and coincides with busy low
    assert_done_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: the parked state is neither busy nor accepting
    assert_park_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!busy && !window_open));

    // R7: sectors join the pending set only from idle or the window
    assert_mask_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.mask & ~$past(r_q.mask))) |->
        ($past(r_q.state) == ST_IDLE || $past(r_q.state) == ST_WINDOW));

    // R11: an erase is only interrupted when the guard has lapsed
    assert_guard_honoured_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SWAIT && $past(r_q.state) == ST_ERASE) |-> $past(guard_idle));

    // R10: sector progress is frozen while parked
    assert_prog_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SUSP) |=> $stable(r_q.prog));

    // R4: erasing never runs with an empty pending set
    assert_erase_has_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ERASE) |-> (r_q.mask != '0));

endmodule

// File: tb/multi_erase_sched_bench.sv
module multi_erase_sched_bench;

    localparam int NS = 7;
    localparam int IW = 3;
    localparam int W  = 50;
    localparam int SC = 60;
    localparam int SL = 20;
    localparam int RG = 40;
    localparam int TL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase_req = 1'b0;
    logic [IW-1:0] erase_sector = '0;
    logic          suspend_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          abort_req = 1'b0;
    logic          term_req = 1'b0;
    logic          busy, window_open, suspended, done;
    logic [IW-1:0] cur_sector;

    int errors = 0;
    int checks = 0;
    int done_seen = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // bench model state: 0 idle,1 window,2 erase,3 suspend wait,4 parked,5 terminate
    int m_st = 0;
    int m_mask = 0;
    int m_tmr = 0;
    int m_prog = 0;
    int m_guard = 0;
    bit m_done = 1'b0;

    always #4 clk = ~clk;

    multi_erase_sched #(
        .NUM_SECTORS (NS), .IDX_W (IW), .WINDOW_CYC (W), .SECTOR_CYC (SC),
        .SUSP_LAT (SL), .RESUME_GUARD (RG), .TERM_LAT (TL)
    ) u_multi_erase_sched (
        .clk (clk), .rst_n (rst_n), .erase_req (erase_req), .erase_sector (erase_sector),
        .suspend_req (suspend_req), .resume_req (resume_req), .abort_req (abort_req),
        .term_req (term_req), .busy (busy), .window_open (window_open),
        .suspended (suspended), .cur_sector (cur_sector), .done (done)
    );

    function automatic int low_idx(int m);
        for (int i = 0; i < NS; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [6:0] exp_vec();
        bit b, wo, su;
        int cs;
        b  = (m_st == 1) || (m_st == 2) || (m_st == 3) || (m_st == 5);
        wo = (m_st == 1);
        su = (m_st == 4);
        cs = (m_st == 2 || m_st == 3 || m_st == 4) ? low_idx(m_mask) : 0;
        return {b, wo, su, m_done, 3'(cs)};
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic compare();
        logic [6:0] act;
        act = {busy, window_open, suspended, done, cur_sector};
        chk(act == exp_vec(), tag, "busy/win/susp/done/cur", int'(act), int'(exp_vec()));
    endtask

    task automatic model_step(bit er, int es, bit sp, bit rs, bit ab, bit tm);
        bit g0;
        bit ev;
        g0 = (m_guard == 0);
        ev = er && (es < NS);
        m_done = 1'b0;
        if (m_guard > 0) m_guard--;
        case (m_st)
            0: if (ev) begin m_st = 1; m_mask = 1 << es; m_tmr = W; end
            1: begin
                if (tm) begin m_st = 5; m_tmr = TL; end
                else if (ab) begin m_st = 0; m_mask = 0; end
                else if (sp) begin m_st = 4; m_prog = 0; end
                else if (ev) begin m_mask |= (1 << es); m_tmr = W; end
                else if (m_tmr == 1) begin m_st = 2; m_prog = 0; end
                else m_tmr--;
            end
            2: begin
                if (tm) begin m_st = 5; m_tmr = TL; end
                else if (sp && g0) begin m_st = 3; m_tmr = SL; end
                else if (m_prog == SC - 1) begin
                    m_mask &= ~(1 << low_idx(m_mask));
                    m_prog = 0;
                    if (m_mask == 0) begin m_st = 0; m_done = 1'b1; end
                end else m_prog++;
            end
            3: begin
                if (tm) begin m_st = 5; m_tmr = TL; end
                else if (m_tmr == 1) m_st = 4;
                else m_tmr--;
            end
            4: begin
                if (tm) begin m_st = 5; m_tmr = TL; end
                else if (rs) begin m_st = 2; m_guard = RG; end
            end
            5: if (m_tmr == 1) begin m_st = 0; m_mask = 0; m_prog = 0; end
               else m_tmr--;
            default: m_st = 0;
        endcase
    endtask

    // called at a falling edge; applies one cycle of inputs and checks the result
    task automatic tick(bit er, int es, bit sp, bit rs, bit ab, bit tm);
        erase_req = er; erase_sector = IW'(es); suspend_req = sp;
        resume_req = rs; abort_req = ab; term_req = tm;
        @(posedge clk);
        model_step(er, es, sp, rs, ab, tm);
        @(negedge clk);
        erase_req = 1'b0; suspend_req = 1'b0; resume_req = 1'b0;
        abort_req = 1'b0; term_req = 1'b0;
        if (done) done_seen++;
        compare();
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
    endtask

    task automatic req(int s);
        tick(1, s, 0, 0, 0, 0);
    endtask

    task automatic run_idle();
        for (int i = 0; i < 3000 && m_st != 0 && m_st != 4; i++) quiet(1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare();
        quiet(2);

        tag = "R2";
        req(7);
        chk(busy == 1'b0, "R2", "busy after out-of-range index", int'(busy), 0);
        req(2);
        quiet(W + 5);
        run_idle();

        tag = "R3";
        req(5); quiet(30); req(1); quiet(W - 1); req(3);
        run_idle();

        tag = "R4";
        req(6); req(0); req(3);
        quiet(W);
        chk(cur_sector == 3'd0, "R4", "first sector erased", int'(cur_sector), 0);
        run_idle();

        tag = "R5";
        done_seen = 0;
        req(4);
        run_idle();
        chk(done_seen == 1, "R5", "done pulse count", done_seen, 1);

        tag = "R6";
        done_seen = 0;
        req(1); req(2); quiet(10);
        tick(0, 0, 0, 0, 1, 0);
        chk(busy == 1'b0, "R6", "busy after abort", int'(busy), 0);
        quiet(W + 5);
        chk(done_seen == 0, "R6", "done after abort", done_seen, 0);

        tag = "R7";
        req(0); quiet(W + 3);
        req(5); tick(0, 0, 0, 0, 1, 0); tick(0, 0, 0, 1, 0, 0); req(2);
        run_idle();

        tag = "R8";
        req(3); quiet(5);
        tick(0, 0, 1, 0, 0, 0);
        chk(suspended == 1'b1, "R8", "parked after window suspend", int'(suspended), 1);
        quiet(4);

        tag = "R10";
        tick(0, 0, 0, 1, 0, 0);
        run_idle();

        tag = "R9";
        req(2); req(4); quiet(W + 20);
        tick(0, 0, 1, 0, 0, 0);
        quiet(SL + 3);
        chk(suspended == 1'b1, "R9", "parked after latency", int'(suspended), 1);

        tag = "R11";
        tick(0, 0, 0, 1, 0, 0);
        tick(0, 0, 1, 0, 0, 0);
        chk(busy == 1'b1 && !suspended, "R11", "suspend inside guard", int'(suspended), 0);
        quiet(RG);
        tick(0, 0, 1, 0, 0, 0);
        quiet(SL + 2);

        tag = "R10";
        tick(0, 0, 0, 1, 0, 0);
        run_idle();

        tag = "R12";
        done_seen = 0;
        tick(0, 0, 0, 0, 0, 1);
        req(1); quiet(3); tick(0, 0, 0, 0, 0, 1); quiet(TL + 2);
        req(1); quiet(W + 10); tick(0, 0, 0, 0, 0, 1); quiet(TL + 2);
        req(6); tick(0, 0, 1, 0, 0, 0); tick(0, 0, 0, 0, 0, 1); quiet(TL + 2);
        chk(done_seen == 0, "R12", "done after terminate", done_seen, 0);

        tag = "R13";
        req(2); tick(1, 4, 0, 0, 1, 1); quiet(TL + 2);
        req(2); tick(1, 4, 1, 0, 1, 0); quiet(3);
        req(2); tick(1, 4, 1, 0, 0, 0); tick(0, 0, 0, 1, 0, 0); run_idle();
        req(5);
        while (!(m_st == 1 && m_tmr == 1)) quiet(1);
        req(0);
        chk(window_open == 1'b1, "R13", "window after expiry-cycle request", int'(window_open), 1);
        run_idle();

        for (int i = 0; i < 6000; i++) begin
            bit er, sp, rs, ab, tm;
            er = ($urandom % 8) == 0;
            sp = ($urandom % 40) == 0;
            rs = ($urandom % 15) == 0;
            ab = ($urandom % 120) == 0;
            tm = ($urandom % 400) == 0;
            tick(er, int'($urandom % 8), sp, rs, ab, tm);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule